// File: doc/BRIEF.md
# Bounded Next-Event Assertion Monitor

This block checks one temporal rule while the chip runs. A cycle in which `trig_i` is high opens an attempt. From that cycle onward the attempt counts the cycles in which `evt_i` is high. For every counted event whose ordinal falls between `K_FIRST` and `L_LAST` inclusive, `prop_i` must be high in that same cycle. The ordinal is 1 for the first counted event, and an event in the trigger cycle itself is the first. Once the `L_LAST`-th event has been seen, the attempt closes. An attempt whose window is still open when the trace stops is never reported as a failure.

Several attempts can be open at once. Each one holds its own occurrence counter in a pool of `MAX_ATTEMPTS` slots. A failing sample produces a one-cycle `fail_pulse_o` in the following cycle and sets the sticky `err_o`. A trigger that finds every slot busy sets the sticky `ovf_o`, and that trigger's attempt is not tracked. The trigger may be any compound condition, for example a flag ANDed with a bus compare, formed outside the block. All inputs are sampled on the rising clock edge, and `rst_i` is synchronous and active high.

Top module: `next_event_monitor`

## Requirements
- R1: While `rst_i` is high at a rising edge, all attempts are dropped and `fail_pulse_o`, `err_o` and `ovf_o` read 0 after that edge.
- R2: With no attempt open and `trig_i` low, no combination of `evt_i` and `prop_i` produces a failure.
- R3: A failure is signalled only for a cycle in which `evt_i` is high, an open attempt reaches an ordinal from `K_FIRST` to `L_LAST`, and `prop_i` is low. `fail_pulse_o` is high for exactly the one cycle after each such sampled edge.
- R4: When `prop_i` is low at ordinals below `K_FIRST`, no failure results.
- R5: An `evt_i` that is high in the trigger cycle counts as ordinal 1 of the attempt that this trigger opens.
- R6: An attempt closes at its `L_LAST`-th event, and later events with `prop_i` low do not fail it.
- R7: Overlapping attempts count their events independently. One event can be inside the window of one attempt and below the window of another.
- R8: A trigger that needs a slot while all `MAX_ATTEMPTS` slots are busy sets `ovf_o` after that edge. The flag stays set until reset.
- R9: `err_o` rises together with the first `fail_pulse_o` and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge samples everything |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Attempt start condition |
| evt_i | input | 1 | Event being counted |
| prop_i | input | 1 | Property required at counted events in the window |
| fail_pulse_o | output | 1 | One-cycle failure indication |
| err_o | output | 1 | Sticky failure flag |
| ovf_o | output | 1 | Sticky attempt-pool overflow flag |

## Verification
Two functions can fall on the same event cycle: the window check of an older attempt and the sub-window counting of a younger one. They also meet when a trigger and an event share a cycle, because the new attempt must count and check that event at once. The overlap case starts a second attempt two cycles after the first, so that one shared event is ordinal 2 of the first attempt and ordinal 1 of the second, with `prop_i` low. The event is judged correct when exactly one pulse follows it. The trigger-plus-event case is judged by where the first failure appears in the next event cycle.

// File: rtl/next_event_monitor.sv
module next_event_monitor #(
  parameter int K_FIRST      = 1,
  parameter int L_LAST       = 3,
  parameter int MAX_ATTEMPTS = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic trig_i,
  input  logic evt_i,
  input  logic prop_i,
  output logic fail_pulse_o,
  output logic err_o,
  output logic ovf_o
);

  localparam int CW = $clog2(L_LAST + 1);
  localparam int IW = (MAX_ATTEMPTS > 1) ? $clog2(MAX_ATTEMPTS) : 1;
  localparam logic [CW-1:0] KC = CW'(K_FIRST);
  localparam logic [CW-1:0] LC = CW'(L_LAST);

  logic [MAX_ATTEMPTS-1:0] busy_q;
  logic [CW-1:0]           cnt_q [MAX_ATTEMPTS];
  logic [MAX_ATTEMPTS-1:0] hit, retire;
  logic [IW-1:0]           alloc_idx;
  logic                    have_free;

  // newly opened attempt: the trigger-cycle event is ordinal 1
  wire new_hit   = trig_i && evt_i && (K_FIRST == 1) && !prop_i;
  wire new_done  = trig_i && evt_i && (L_LAST == 1);
  wire need_slot = trig_i && !new_done;
  wire alloc     = need_slot && have_free;
  wire fail_now  = (|hit) || new_hit;

  genvar g;
  generate
    for (g = 0; g < MAX_ATTEMPTS; g++) begin : g_slot
      wire [CW-1:0] occ = cnt_q[g] + CW'(1);
      assign hit[g]    = busy_q[g] && evt_i && !prop_i && (occ >= KC) && (occ <= LC);
      assign retire[g] = busy_q[g] && evt_i && (occ == LC);

      always_ff @(posedge clk_i) begin
        if (rst_i) begin
          busy_q[g] <= 1'b0;
          cnt_q[g]  <= '0;
        end else if (alloc && alloc_idx == IW'(g)) begin
          busy_q[g] <= 1'b1;
          cnt_q[g]  <= evt_i ? CW'(1) : CW'(0);
        end else if (retire[g]) begin
          busy_q[g] <= 1'b0;
          cnt_q[g]  <= '0;
        end else if (busy_q[g] && evt_i) begin
          cnt_q[g]  <= occ;
        end
      end

      // R6
      slot_window_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        busy_q[g] |-> (cnt_q[g] < LC));
    end
  endgenerate

  always_comb begin
    have_free = 1'b0;
    alloc_idx = '0;
    for (int i = MAX_ATTEMPTS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        have_free = 1'b1;
        alloc_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      fail_pulse_o <= 1'b0;
      err_o        <= 1'b0;
      ovf_o        <= 1'b0;
    end else begin
      fail_pulse_o <= fail_now;
      err_o        <= err_o || fail_now;
      ovf_o        <= ovf_o || (need_slot && !have_free);
    end
  end

  // R2
  no_spurious_fail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!trig_i && busy_q == '0) |=> !fail_pulse_o);

  // R3
  fail_needs_event_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !evt_i |=> !fail_pulse_o);

  // R9
  err_follows_fail_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fail_pulse_o |-> err_o);

  // R9
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    err_o |=> err_o);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    ovf_o |=> ovf_o);

  // R8
  ovf_on_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (need_slot && (&busy_q)) |=> ovf_o);

endmodule

// File: tb/next_event_monitor_tb_top.sv
module next_event_monitor_tb_top;
  logic clk = 1'b0, rst, trig, evt, prop;
  logic fail_pulse, err, ovf;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  next_event_monitor #(.K_FIRST(2), .L_LAST(4), .MAX_ATTEMPTS(2)) dut_i (
    .clk_i(clk), .rst_i(rst), .trig_i(trig), .evt_i(evt), .prop_i(prop),
    .fail_pulse_o(fail_pulse), .err_o(err), .ovf_o(ovf));

  function automatic logic hi(byte c);
    return (c == "1" || c == "-");
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic do_reset();
    rst = 1; trig = 0; evt = 0; prop = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "fail_pulse in reset", fail_pulse, 1'b0);
    check("R1", "err in reset", err, 1'b0);
    check("R1", "ovf in reset", ovf, 1'b0);
    rst = 0;
  endtask

  // drive one character per cycle, check the registered outputs after each edge
  task automatic run(string tag, string t, string e, string p, string xf, string xo);
    for (int i = 0; i < t.len(); i++) begin
      trig = hi(t[i]); evt = hi(e[i]); prop = hi(p[i]);
      @(posedge clk);
      @(negedge clk);
      check(tag, $sformatf("fail_pulse cycle %0d", i), fail_pulse, hi(xf[i]));
      check(tag, $sformatf("ovf cycle %0d", i), ovf, hi(xo[i]));
    end
    trig = 0; evt = 0; prop = 0;
  endtask

  task automatic t_idle();   // R1 R2
    do_reset();
    run("R2", "____", "----", "____", "____", "____");
    check("R2", "err idle", err, 1'b0);
  endtask

  task automatic t_pass();   // R6: occurrences 1..4 hold, fifth after retirement
    do_reset();
    run("R6", "-_________", "_-_-_-_-_-", "_-_-_-_-__", "__________", "__________");
    check("R6", "err after pass", err, 1'b0);
  endtask

  task automatic t_mid_fail(); // R3 R4 R9
    do_reset();
    run("R3", "-_________", "__--__--__", "___-___-__", "______-___", "__________");
    check("R9", "err set", err, 1'b1);
    run("R9", "____", "____", "____", "____", "____");
    check("R9", "err held", err, 1'b1);
    do_reset();
    check("R1", "err cleared", err, 1'b0);
  endtask

  task automatic t_coincide(); // R5
    do_reset();
    run("R5", "_-_____", "_--____", "_______", "__-____", "_______");
  endtask

  task automatic t_overlap();  // R7
    do_reset();
    run("R7", "-_-_______", "_-_-_-_-_-", "---_-----_", "___-_____-", "__________");
  endtask

  task automatic t_overflow(); // R8
    do_reset();
    run("R8", "---___", "______", "______", "______", "__----");
    check("R8", "err unaffected", err, 1'b0);
  endtask

  initial begin
    rst = 1; trig = 0; evt = 0; prop = 0;
    t_idle();
    t_pass();
    t_mid_fail();
    t_coincide();
    t_overlap();
    t_overflow();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule